// File: doc/BRIEF.md
# Single-Line Open-Drain Bus Master Bit Engine

This block is the bit-level master for a single-wire, open-drain serial bus with a pull-up. A host hands it one operation at a time: a bus reset with a presence check, a write-0 slot, a write-1 slot, or a read slot. The engine times each operation in whole microseconds from a tick that it derives from the system clock. It drives the line only by enabling a pull-down, and it reads the line through a two-flop synchronizer. Because the line is open-drain, the level it samples is the wired-AND of its own pull-down and every slave's pull-down.

The host presents an operation code together with a valid strobe. The engine accepts the operation on any cycle where it is not busy. It holds `busy` high until the whole slot has finished, including the recovery time. A reset also covers the full listening window before the next command. After a reset, the host reads the presence result. After a read slot, it reads the sampled bit. Both results stay unchanged until an operation of the same kind samples again.

The reset low time is clamped at elaboration. It is never shorter than 480 µs. It is also never longer than a cap chosen so that the low time plus the line's rise time stays below 960 µs, which keeps other slaves' interrupt signaling from being masked.

Top module: `owm_bit_engine`

## Requirements
- R1: After reset, `busy`, `line_oe`, `presence` and `rd_bit` are all 0, and `line_oe` is never 1 while `busy` is 0.
- R2: The engine accepts an operation on a clock edge where `cmd_valid` is 1 and `busy` is 0. `busy` then reads 1 from the next cycle until the slot ends. A `cmd_valid` seen while `busy` is 1 is ignored: it does not change the line drive or the slot length.
- R3: For operation code 2'b00 (reset), `line_oe` is high for the clamped reset low time, where the clamped time is `RST_LOW_US` limited to the range [480, `RST_CAP_US`] µs (`RST_CAP_US` defaults to 940). The line is never driven low for longer than `RST_CAP_US` µs.
- R4: A reset operation keeps `busy` high for the clamped low time plus the listening window. The listening window is `RST_HIGH_US` µs, raised to at least 480 µs.
- R5: A reset samples the synchronized line once, 70 µs after the line is released. `presence` becomes 1 if the line is low at that point and 0 otherwise.
- R6: Operation code 2'b10 (write 1) drives the line low for 6 µs, and `busy` covers a 70 µs slot.
- R7: Operation code 2'b01 (write 0) drives the line low for 60 µs, and `busy` covers a 70 µs slot.
- R8: Operation code 2'b11 (read) drives the line low for 6 µs and samples the synchronized line 15 µs after the slot starts. `rd_bit` takes the sampled level (a slave holding the line low gives 0). `busy` covers a 70 µs slot.
- R9: Write slots leave `presence` and `rd_bit` unchanged. A read slot leaves `presence` unchanged. A reset leaves `rd_bit` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host strobe for a new operation |
| cmd_op | input | 2 | Operation: 00 reset, 01 write 0, 10 write 1, 11 read |
| busy | output | 1 | High from accept until the slot or reset window ends |
| presence | output | 1 | Result of the last reset's presence sample |
| rd_bit | output | 1 | Result of the last read slot |
| line_oe | output | 1 | Enable for the open-drain pull-down (1 pulls the line low) |
| line_in | input | 1 | Raw level of the bus line, asynchronous |

## Verification
The bench builds the engine with `CLK_PER_US` set to 4, so one microsecond is four clock cycles. Every slot and the full reset window then complete in a few thousand cycles, and the expected counts of drive and busy cycles come out as exact multiples of four. Two further instances receive `RST_LOW_US` values of 2000 and 100. These bring both the upper and the lower clamp of the reset low time within reach, together with the longer busy windows that follow from each clamp. A small slave model in the bench answers resets and read slots through the wired-AND line, so that both outcomes of each sample can be checked.

// File: rtl/owm_pkg.sv
package owm_pkg;

  localparam int US_W       = 16;
  localparam int RST_MIN_US = 480;
  localparam int HIGH_MIN_US = 480;

  typedef enum logic [1:0] {
    OP_RESET = 2'b00,
    OP_WR0   = 2'b01,
    OP_WR1   = 2'b10,
    OP_READ  = 2'b11
  } owm_op_e;

  typedef enum logic [1:0] {
    SAMP_NONE = 2'd0,
    SAMP_PRES = 2'd1,
    SAMP_BIT  = 2'd2
  } samp_e;

  typedef struct packed {
    logic [US_W-1:0] low_us;
    logic [US_W-1:0] samp_us;
    logic [US_W-1:0] total_us;
    samp_e           kind;
  } slot_plan_t;

  function automatic int clamp_us(int v, int lo, int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic int max_us(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic slot_plan_t plan_slot(owm_op_e op, int rst_low, int rst_high,
                                           int pres_off, int slot_us, int w1_low,
                                           int w0_low, int rd_low, int rd_samp);
    slot_plan_t p;
    case (op)
      OP_RESET: begin
        p.low_us   = US_W'(rst_low);
        p.samp_us  = US_W'(rst_low + pres_off);
        p.total_us = US_W'(rst_low + rst_high);
        p.kind     = SAMP_PRES;
      end
      OP_WR0: begin
        p.low_us   = US_W'(w0_low);
        p.samp_us  = '0;
        p.total_us = US_W'(slot_us);
        p.kind     = SAMP_NONE;
      end
      OP_WR1: begin
        p.low_us   = US_W'(w1_low);
        p.samp_us  = '0;
        p.total_us = US_W'(slot_us);
        p.kind     = SAMP_NONE;
      end
      default: begin
        p.low_us   = US_W'(rd_low);
        p.samp_us  = US_W'(rd_samp);
        p.total_us = US_W'(slot_us);
        p.kind     = SAMP_BIT;
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/owm_us_tick.sv
module owm_us_tick #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

  logic [PW-1:0] pre_cnt;
  logic          wrap;

  assign wrap = (pre_cnt == LAST);
  assign tick = wrap && !clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || wrap) pre_cnt <= '0;
    else                       pre_cnt <= pre_cnt + 1'b1;
  end

  a_r2_tick_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_cnt == '0) || (CLK_PER_US == 1));
endmodule

// File: rtl/owm_sync2.sv
module owm_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic q1, q2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q1 <= 1'b1;
      q2 <= 1'b1;
    end else begin
      q1 <= d_async;
      q2 <= q1;
    end
  end

  assign q_sync = q2;
endmodule

// File: rtl/owm_slot_ctrl.sv
module owm_slot_ctrl
  import owm_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int RST_CAP_US  = 940,
  parameter int RST_LOW_EFF = 500,
  parameter int RST_HI_EFF  = 500,
  parameter int PRES_OFF_US = 70,
  parameter int SLOT_US     = 70,
  parameter int W1_LOW_US   = 6,
  parameter int W0_LOW_US   = 60,
  parameter int RD_LOW_US   = 6,
  parameter int RD_SAMP_US  = 15
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cmd_accept,
  input  owm_op_e cmd_op,
  input  logic    tick,
  input  logic    line_s,
  output logic    busy,
  output logic    line_oe,
  output logic    presence,
  output logic    rd_bit,
  output logic    slot_end,
  output logic    pres_ev,
  output logic    bit_ev
);
  localparam int RUN_LIM = RST_CAP_US * CLK_PER_US;
  localparam int RUN_W   = $clog2(RUN_LIM + 2);

  slot_plan_t      plan, next_plan;
  logic [US_W-1:0] us_cnt;
  logic            samp_hit;
  logic [RUN_W-1:0] oe_run;

  always_comb next_plan = plan_slot(cmd_op, RST_LOW_EFF, RST_HI_EFF, PRES_OFF_US, SLOT_US,
                                    W1_LOW_US, W0_LOW_US, RD_LOW_US, RD_SAMP_US);

  assign line_oe  = busy && (us_cnt < plan.low_us);
  assign slot_end = busy && tick && (us_cnt == plan.total_us - 1'b1);
  assign samp_hit = busy && tick && (us_cnt == plan.samp_us - 1'b1);
  assign pres_ev  = samp_hit && (plan.kind == SAMP_PRES);
  assign bit_ev   = samp_hit && (plan.kind == SAMP_BIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      us_cnt   <= '0;
      plan     <= '0;
      presence <= 1'b0;
      rd_bit   <= 1'b0;
    end else begin
      if (cmd_accept) begin
        busy   <= 1'b1;
        us_cnt <= '0;
        plan   <= next_plan;
      end else if (busy && tick) begin
        us_cnt <= us_cnt + 1'b1;
        if (slot_end) busy <= 1'b0;
      end
      if (pres_ev) presence <= ~line_s;
      if (bit_ev)  rd_bit   <= line_s;
    end
  end

  // consecutive cycles of pull-down, used to guard the reset cap
  always_ff @(posedge clk) begin
    if (!rst_n || !line_oe)             oe_run <= '0;
    else if (oe_run <= RUN_W'(RUN_LIM)) oe_run <= oe_run + 1'b1;
  end

  a_r1_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe);
  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);
  a_r2_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !slot_end) |=> busy);
  a_r3_low_cap: assert property (@(posedge clk) disable iff (!rst_n)
    line_oe |-> (oe_run < RUN_W'(RUN_LIM)));
  a_r9_pres_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pres_ev |=> $stable(presence));
  a_r9_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_ev |=> $stable(rd_bit));
  a_r5_one_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pres_ev, bit_ev}));
endmodule

// File: rtl/owm_bit_engine.sv
module owm_bit_engine
  import owm_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int RST_LOW_US  = 500,
  parameter int RST_CAP_US  = 940,
  parameter int RST_HIGH_US = 500,
  parameter int PRES_OFF_US = 70,
  parameter int SLOT_US     = 70,
  parameter int W1_LOW_US   = 6,
  parameter int W0_LOW_US   = 60,
  parameter int RD_LOW_US   = 6,
  parameter int RD_SAMP_US  = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       busy,
  output logic       presence,
  output logic       rd_bit,
  output logic       line_oe,
  input  logic       line_in
);
  localparam int RST_LOW_EFF = clamp_us(RST_LOW_US, RST_MIN_US, RST_CAP_US);
  localparam int RST_HI_EFF  = max_us(RST_HIGH_US, HIGH_MIN_US);

  logic cmd_accept, tick, line_s, slot_end, pres_ev, bit_ev;

  assign cmd_accept = cmd_valid && !busy;

  owm_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(cmd_accept), .tick(tick)
  );

  owm_sync2 u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(line_in), .q_sync(line_s)
  );

  owm_slot_ctrl #(
    .CLK_PER_US(CLK_PER_US), .RST_CAP_US(RST_CAP_US),
    .RST_LOW_EFF(RST_LOW_EFF), .RST_HI_EFF(RST_HI_EFF),
    .PRES_OFF_US(PRES_OFF_US), .SLOT_US(SLOT_US),
    .W1_LOW_US(W1_LOW_US), .W0_LOW_US(W0_LOW_US),
    .RD_LOW_US(RD_LOW_US), .RD_SAMP_US(RD_SAMP_US)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_accept(cmd_accept),
    .cmd_op(owm_op_e'(cmd_op)), .tick(tick), .line_s(line_s),
    .busy(busy), .line_oe(line_oe), .presence(presence), .rd_bit(rd_bit),
    .slot_end(slot_end), .pres_ev(pres_ev), .bit_ev(bit_ev)
  );

  a_r2_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && !slot_end) |=> busy);
endmodule

// File: tb/owm_bit_engine_tb.sv
module owm_bit_engine_tb;
  localparam int CPU = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic busy, presence, rd_bit, line_oe, line_in;
  logic slave_pull = 1'b0;

  logic xvalid = 1'b0;
  logic busy_c, pres_c, bit_c, oe_c;
  logic busy_m, pres_m, bit_m, oe_m;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign line_in = ~(line_oe | slave_pull);

  owm_bit_engine #(.CLK_PER_US(CPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .presence(presence), .rd_bit(rd_bit),
    .line_oe(line_oe), .line_in(line_in)
  );

  owm_bit_engine #(.CLK_PER_US(CPU), .RST_LOW_US(2000)) u_dut_cap (
    .clk(clk), .rst_n(rst_n), .cmd_valid(xvalid), .cmd_op(2'b00),
    .busy(busy_c), .presence(pres_c), .rd_bit(bit_c),
    .line_oe(oe_c), .line_in(~oe_c)
  );

  owm_bit_engine #(.CLK_PER_US(CPU), .RST_LOW_US(100)) u_dut_min (
    .clk(clk), .rst_n(rst_n), .cmd_valid(xvalid), .cmd_op(2'b00),
    .busy(busy_m), .presence(pres_m), .rd_bit(bit_m),
    .line_oe(oe_m), .line_in(~oe_m)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // issue one op on the main instance, count busy and drive cycles
  task automatic run_op(input logic [1:0] op, input bit inject,
                        output int bcnt, output int ocnt);
    @(negedge clk);
    cmd_op = op;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    bcnt = 0;
    ocnt = 0;
    while (busy) begin
      if (line_oe) ocnt++;
      bcnt++;
      if (inject && bcnt == 100) begin cmd_op = 2'b00; cmd_valid = 1'b1; end
      if (inject && bcnt == 101) cmd_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state();
    check("R1 busy", busy, 0);
    check("R1 line_oe", line_oe, 0);
    check("R1 presence", presence, 0);
    check("R1 rd_bit", rd_bit, 0);
  endtask

  task automatic t_reset(input bit answer, input int exp_pres);
    int b, o;
    fork
      run_op(2'b00, 0, b, o);
      if (answer) begin
        wait (line_oe == 1'b1);
        wait (line_oe == 1'b0);
        repeat (20 * CPU) @(posedge clk);
        slave_pull = 1'b1;
        repeat (100 * CPU) @(posedge clk);
        slave_pull = 1'b0;
      end
    join
    check("R3 reset low cycles", o, 500 * CPU);
    check("R4 reset busy cycles", b, 1000 * CPU);
    check("R5 presence", presence, exp_pres);
  endtask

  task automatic t_write1_ignore();
    int b, o;
    logic keep_p, keep_r;
    keep_p = presence;
    keep_r = rd_bit;
    run_op(2'b10, 1, b, o);
    check("R6 write1 low cycles", o, 6 * CPU);
    check("R6 write1 busy cycles", b, 70 * CPU);
    check("R2 busy after ignored cmd", busy, 0);
    check("R9 presence after write1", presence, keep_p);
    check("R9 rd_bit after write1", rd_bit, keep_r);
  endtask

  task automatic t_write0();
    int b, o;
    logic keep_r;
    keep_r = rd_bit;
    run_op(2'b01, 0, b, o);
    check("R7 write0 low cycles", o, 60 * CPU);
    check("R7 write0 busy cycles", b, 70 * CPU);
    check("R9 rd_bit after write0", rd_bit, keep_r);
  endtask

  task automatic t_read(input bit slave_zero);
    int b, o;
    logic keep_p;
    keep_p = presence;
    fork
      run_op(2'b11, 0, b, o);
      if (slave_zero) begin
        wait (line_oe == 1'b1);
        repeat (2 * CPU) @(posedge clk);
        slave_pull = 1'b1;
        repeat (30 * CPU) @(posedge clk);
        slave_pull = 1'b0;
      end
    join
    check("R8 read low cycles", o, 6 * CPU);
    check("R8 read busy cycles", b, 70 * CPU);
    check("R8 read bit", rd_bit, slave_zero ? 0 : 1);
    check("R9 presence after read", presence, keep_p);
  endtask

  task automatic t_clamps();
    int bc = 0, oc = 0, bm = 0, om = 0;
    @(negedge clk);
    xvalid = 1'b1;
    @(negedge clk);
    xvalid = 1'b0;
    while (busy_c || busy_m) begin
      if (busy_c) bc++;
      if (oe_c) oc++;
      if (busy_m) bm++;
      if (oe_m) om++;
      @(negedge clk);
    end
    check("R3 capped low cycles", oc, 940 * CPU);
    check("R4 capped busy cycles", bc, 1440 * CPU);
    check("R3 raised low cycles", om, 480 * CPU);
    check("R4 raised busy cycles", bm, 980 * CPU);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reset(1, 1);
    t_write1_ignore();
    t_write0();
    t_read(1);
    t_read(0);
    t_reset(0, 0);
    t_write0();
    t_clamps();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule